// File: doc/BRIEF.md
# Shared Counter Multi-Core Comparator Timer

This block is a memory-mapped timer. All cores share one free-running up-counter, and each core has its own compare channel. A shared prescaler slows the counter: while the timer runs, the counter moves up by one after every `prescale + 1` clock cycles. Each channel holds a 64-bit comparator, a 32-bit reload step, a small set of banked control bits, a sticky event flag and one interrupt line. A channel flags an event once the counter has reached its comparator value or gone past it. In periodic mode the channel then moves its comparator forward by the step, so the event repeats at a fixed interval.

Software reaches the block through a 32-bit register window. Every access carries the requesting core's ID. The ID selects which banked channel registers the access reaches. The shared fields (run bit, prescaler, counter) are the same for every core. A core ID at or above the configured channel count gets no access.

Top module: `shared_cmp_timer`

## Requirements
- R1: After reset, every register of every channel reads zero, and all interrupt outputs are low.
- R2: While the run bit (control bit 0) is set, the counter increments once every `prescale + 1` clocks, where prescale is control bits 15:8. While the run bit is clear, the counter holds its value.
- R3: Writes to counter word 0x00 (bits 31:0) and word 0x04 (bits 63:32) load that half of the counter while the run bit is clear. The same writes are ignored while the run bit is set. A 32-bit carry propagates from the low word into the high word.
- R4: A channel sets its sticky flag in the cycle after its comparator (low word 0x10, high word 0x14) is less than or equal to the counter. This happens only if the run bit and that channel's compare-enable bit (control bit 1) are both set. If either bit is clear, the flag is not set.
- R5: When the channel's periodic bit (control bit 3) is set, each compare hit adds the 32-bit step (register 0x18) to the comparator, at most once per clock. A step of zero leaves the comparator unchanged, and the flag stays set.
- R6: Each channel's interrupt output is high exactly when its flag is set and its interrupt-enable bit (control bit 2) is set.
- R7: The flag is read at bit 0 of register 0x0C. Writing 1 to that bit clears the flag. Writing 0 to that bit has no effect.
- R8: The run bit and the prescaler are shared, and a control write from any core updates them. Control bits 3:1 are banked per core. A control read returns the shared fields combined with the requester's own banked bits. All other control bits read as zero.
- R9: The register index is taken from address bits 4:2. Offset 0x1C is unmapped: it reads zero, and writes to it change nothing.
- R10: A requester whose core ID is at or above the channel count reads zero at every offset, and its writes change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe for the current cycle |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 5 | Byte offset in the 0x20-byte window |
| bus_wdata | input | 32 | Write data |
| bus_core | input | CORE_ID_W | ID of the requesting core |
| bus_rdata | output | 32 | Combinational read data for bus_addr and bus_core |
| irq | output | NUM_CH | Per-channel interrupt outputs |

## Verification
The bench builds the block with three channels and a 2-bit core ID. With that setting, every valid core's banked set can be swept, and ID 3 exercises the out-of-range path. The counter is 64 bits wide. Compare distances start just below a 32-bit boundary, so the carry into the high word and high-word comparisons are both exercised. The prescaler is swept from 0 to 4, and for each value the bench predicts the exact cycle of each count arithmetically.

// File: rtl/sct_pkg.sv
package sct_pkg;

   // Register index taken from address bits 4:2
   typedef enum logic [2:0] {
      RI_CNT_LO = 3'd0,
      RI_CNT_HI = 3'd1,
      RI_CTRL   = 3'd2,
      RI_STAT   = 3'd3,
      RI_CMP_LO = 3'd4,
      RI_CMP_HI = 3'd5,
      RI_STEP   = 3'd6,
      RI_NONE   = 3'd7
   } reg_idx_e;

   // Banked control bits, packed to match control bits 3:1
   typedef struct packed {
      logic periodic;  // bit 3
      logic irq_en;    // bit 2
      logic cmp_en;    // bit 1
   } ch_ctl_t;

   localparam int RUN_BIT  = 0;
   localparam int PSC_LSB  = 8;

endpackage

// File: rtl/sct_prescaler.sv
module sct_prescaler #(
   parameter int PSC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [PSC_W-1:0] div,
   output logic             tick
);
   logic [PSC_W-1:0] pc_q;

   // >= keeps the divider bounded if div shrinks mid-run
   assign tick = run && (pc_q >= div);

   always_ff @(posedge clk) begin
      if (!rst_n)             pc_q <= '0;
      else if (!run || tick)  pc_q <= '0;
      else                    pc_q <= pc_q + PSC_W'(1);
   end
endmodule

// File: rtl/sct_counter.sv
module sct_counter #(
   parameter int CNT_W = 64
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic             ld_lo,
   input  logic             ld_hi,
   input  logic [31:0]      wdata,
   output logic [CNT_W-1:0] cnt
);
   always_ff @(posedge clk) begin
      if (!rst_n)      cnt <= '0;
      else if (ld_lo)  cnt[31:0] <= wdata;
      else if (ld_hi)  cnt[CNT_W-1:32] <= wdata[CNT_W-33:0];
      else if (tick)   cnt <= cnt + CNT_W'(1);
   end
endmodule

// File: rtl/sct_channel.sv
module sct_channel
   import sct_pkg::*;
#(
   parameter int CNT_W  = 64,
   parameter int STEP_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CNT_W-1:0] cnt,
   input  logic             ctl_we,
   input  logic             stat_we,
   input  logic             cmp_lo_we,
   input  logic             cmp_hi_we,
   input  logic             step_we,
   input  logic [31:0]      wdata,
   output ch_ctl_t          ctl,
   output logic             flag,
   output logic [CNT_W-1:0] cmp,
   output logic [STEP_W-1:0] step,
   output logic             irq
);
   logic hit;
   logic unused_wdata;

   assign unused_wdata = ^{wdata[31:4], wdata[0]};
   assign hit = run && ctl.cmp_en && (cnt >= cmp);
   assign irq = flag && ctl.irq_en;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl  <= '0;
         flag <= 1'b0;
         cmp  <= '0;
         step <= '0;
      end else begin
         if (ctl_we)  ctl <= ch_ctl_t'(wdata[3:1]);
         if (step_we) step <= wdata[STEP_W-1:0];
         // an event in the same cycle outranks a clear
         if (hit)                       flag <= 1'b1;
         else if (stat_we && wdata[0])  flag <= 1'b0;
         if (cmp_lo_we)                 cmp[31:0] <= wdata;
         else if (cmp_hi_we)            cmp[CNT_W-1:32] <= wdata[CNT_W-33:0];
         else if (hit && ctl.periodic)  cmp <= cmp + CNT_W'(step);
      end
   end
endmodule

// File: rtl/shared_cmp_timer.sv
module shared_cmp_timer
   import sct_pkg::*;
#(
   parameter int NUM_CH    = 4,
   parameter int CORE_ID_W = 3,
   parameter int CNT_W     = 64,
   parameter int PSC_W     = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_sel,
   input  logic                 bus_we,
   input  logic [4:0]           bus_addr,
   input  logic [31:0]          bus_wdata,
   input  logic [CORE_ID_W-1:0] bus_core,
   output logic [31:0]          bus_rdata,
   output logic [NUM_CH-1:0]    irq
);
   localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
   localparam int STEP_W = 32;
   localparam int CID_W1 = CORE_ID_W + 1;
   localparam logic [CORE_ID_W:0] NCH_L = CID_W1'(NUM_CH);

   generate
      if (NUM_CH < 1 || NUM_CH > 32)
         $error("NUM_CH must lie in 1..32");
      if (CORE_ID_W < CH_W)
         $error("CORE_ID_W too narrow for NUM_CH");
      if (CNT_W <= 32 || CNT_W > 64)
         $error("CNT_W must lie in 33..64");
      if (PSC_W < 1 || PSC_W > 8)
         $error("PSC_W must lie in 1..8");
   endgenerate

   logic             core_ok;
   logic [CH_W-1:0]  core_ix;
   logic             wr_ok;
   reg_idx_e         ridx;
   logic             unused_addr;

   logic             glob_en_q;
   logic [PSC_W-1:0] psc_q;
   logic             tick;
   logic [CNT_W-1:0] cnt_q;

   ch_ctl_t           ctl_a  [NUM_CH];
   logic [CNT_W-1:0]  cmp_a  [NUM_CH];
   logic [STEP_W-1:0] step_a [NUM_CH];
   logic [NUM_CH-1:0] stat_v;

   assign unused_addr = ^bus_addr[1:0];
   assign core_ok = ({1'b0, bus_core} < NCH_L);
   assign core_ix = core_ok ? bus_core[CH_W-1:0] : '0;
   assign wr_ok   = bus_sel && bus_we && core_ok;
   assign ridx    = reg_idx_e'(bus_addr[4:2]);

   // shared control fields
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         glob_en_q <= 1'b0;
         psc_q     <= '0;
      end else if (wr_ok && ridx == RI_CTRL) begin
         glob_en_q <= bus_wdata[RUN_BIT];
         psc_q     <= bus_wdata[PSC_LSB +: PSC_W];
      end
   end

   sct_prescaler #(.PSC_W(PSC_W)) u_psc (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (glob_en_q),
      .div   (psc_q),
      .tick  (tick)
   );

   sct_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .tick  (tick),
      .ld_lo (wr_ok && !glob_en_q && ridx == RI_CNT_LO),
      .ld_hi (wr_ok && !glob_en_q && ridx == RI_CNT_HI),
      .wdata (bus_wdata),
      .cnt   (cnt_q)
   );

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
         logic mine;
         assign mine = wr_ok && (core_ix == CH_W'(i));

         sct_channel #(.CNT_W(CNT_W), .STEP_W(STEP_W)) u_ch (
            .clk       (clk),
            .rst_n     (rst_n),
            .run       (glob_en_q),
            .cnt       (cnt_q),
            .ctl_we    (mine && ridx == RI_CTRL),
            .stat_we   (mine && ridx == RI_STAT),
            .cmp_lo_we (mine && ridx == RI_CMP_LO),
            .cmp_hi_we (mine && ridx == RI_CMP_HI),
            .step_we   (mine && ridx == RI_STEP),
            .wdata     (bus_wdata),
            .ctl       (ctl_a[i]),
            .flag      (stat_v[i]),
            .cmp       (cmp_a[i]),
            .step      (step_a[i]),
            .irq       (irq[i])
         );
      end
   endgenerate

   // combinational read path
   logic [63:0] cnt64;
   logic [63:0] cmp64;
   assign cnt64 = 64'(cnt_q);
   assign cmp64 = 64'(cmp_a[core_ix]);

   always_comb begin
      bus_rdata = '0;
      if (core_ok) begin
         unique case (ridx)
            RI_CNT_LO: bus_rdata = cnt64[31:0];
            RI_CNT_HI: bus_rdata = cnt64[63:32];
            RI_CTRL:   bus_rdata = {16'd0, 8'(psc_q), 4'd0,
                                    ctl_a[core_ix], glob_en_q};
            RI_STAT:   bus_rdata = {31'd0, stat_v[core_ix]};
            RI_CMP_LO: bus_rdata = cmp64[31:0];
            RI_CMP_HI: bus_rdata = cmp64[63:32];
            RI_STEP:   bus_rdata = step_a[core_ix];
            RI_NONE:   bus_rdata = '0;
            default:   bus_rdata = '0;
         endcase
      end
   end
endmodule

// File: rtl/sct_checker.sv
module sct_checker #(
   parameter int NUM_CH    = 4,
   parameter int CORE_ID_W = 3,
   parameter int CNT_W     = 64
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic                 bus_sel,
   input logic                 bus_we,
   input logic [4:0]           bus_addr,
   input logic [31:0]          bus_wdata,
   input logic [CORE_ID_W-1:0] bus_core,
   input logic                 glob_en,
   input logic [CNT_W-1:0]     cnt,
   input logic [NUM_CH-1:0]    stat,
   input logic [NUM_CH-1:0]    irq
);
   // R2: stopped counter only moves through a bus write
   assert_hold_when_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!glob_en && !(bus_sel && bus_we)) |=> $stable(cnt));

   // R3: running counter never jumps; loads are refused
   assert_step_one_R3: assert property (@(posedge clk) disable iff (!rst_n)
      glob_en |=> ((cnt - $past(cnt)) <= CNT_W'(1)));

   // R6: with the timer stopped and no bus write, interrupts stay put
   assert_irq_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!glob_en && !(bus_sel && bus_we)) |=> $stable(irq));

   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_a
         // R4: a flag rises only while the timer runs
         assert_set_needs_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(stat[i]) |-> $past(glob_en));
         // R7: a flag falls only through a write of 1 to its own status bit
         assert_clear_by_w1c_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(stat[i]) |-> $past(bus_sel && bus_we && bus_addr[4:2] == 3'd3
                                     && bus_wdata[0] && bus_core == CORE_ID_W'(i)));
      end
   endgenerate
endmodule

bind shared_cmp_timer sct_checker #(
   .NUM_CH(NUM_CH), .CORE_ID_W(CORE_ID_W), .CNT_W(CNT_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_sel   (bus_sel),
   .bus_we    (bus_we),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_core  (bus_core),
   .glob_en   (glob_en_q),
   .cnt       (cnt_q),
   .stat      (stat_v),
   .irq       (irq)
);

// File: tb/sim_shared_cmp_timer.sv
module sim_shared_cmp_timer;
   timeunit 1ns;
   timeprecision 1ps;

   localparam int NCH = 3;
   localparam int CIW = 2;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_we = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [CIW-1:0] bus_core = '0;
   logic [31:0] bus_rdata;
   logic [NCH-1:0] irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   localparam logic [4:0] A_CLO = 5'h00, A_CHI = 5'h04, A_CTL = 5'h08,
                          A_STA = 5'h0C, A_KLO = 5'h10, A_KHI = 5'h14,
                          A_STP = 5'h18, A_BAD = 5'h1C;

   always #10 clk = ~clk;   // 50 MHz

   shared_cmp_timer #(.NUM_CH(NCH), .CORE_ID_W(CIW), .CNT_W(64), .PSC_W(8)) u0 (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_core(bus_core),
      .bus_rdata(bus_rdata), .irq(irq)
   );

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [CIW-1:0] c, input logic [4:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_core = c; bus_addr = a; bus_wdata = d; bus_sel = 1'b1; bus_we = 1'b1;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic rd(input logic [CIW-1:0] c, input logic [4:0] a, output logic [31:0] d);
      bus_core = c; bus_addr = a;
      #0.1;
      d = bus_rdata;
   endtask

   task automatic stop_clear(input logic [CIW-1:0] c);
      wr(c, A_CTL, 32'h0);
      wr(c, A_STA, 32'h1);
   endtask

   task automatic finish_run;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #(20ns * 100000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected done");
         finish_run();
      end
   end

   initial begin
      logic [31:0] d;
      logic [63:0] k;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      for (int c = 0; c < NCH; c++)
         for (int a = 0; a < 7; a++) begin
            rd(CIW'(c), 5'(a * 4), d);
            chk($sformatf("R1 core%0d off%0h", c, a * 4), 64'(d), 64'd0);
         end
      chk("R1 irq", 64'(irq), 64'd0);

      // R3: load while stopped, ignore while running
      wr(0, A_CLO, 32'd100);
      wr(0, A_CHI, 32'd5);
      rd(0, A_CLO, d); chk("R3 load lo", 64'(d), 64'd100);
      rd(0, A_CHI, d); chk("R3 load hi", 64'(d), 64'd5);
      wr(0, A_CHI, 32'd0);
      wr(0, A_CTL, 32'h0000_FF01);
      wr(0, A_CLO, 32'h5555);
      wr(0, A_CHI, 32'd7);
      rd(0, A_CLO, d); chk("R3 ignored lo", 64'(d), 64'd100);
      rd(0, A_CHI, d); chk("R3 ignored hi", 64'(d), 64'd0);
      wr(0, A_CTL, 32'h0);

      // R2: prescaler sweep
      for (int p = 0; p < 5; p++) begin
         wr(0, A_CTL, 32'h0);
         wr(0, A_CLO, 32'd0);
         wr(0, A_CTL, 32'(p << 8) | 32'h1);
         repeat (3 * (p + 1) - 1) @(negedge clk);
         rd(0, A_CLO, d); chk($sformatf("R2 psc%0d before", p), 64'(d), 64'd2);
         @(negedge clk);
         rd(0, A_CLO, d); chk($sformatf("R2 psc%0d at", p), 64'(d), 64'd3);
         wr(0, A_CTL, 32'h0);
         rd(0, A_CLO, d); k = 64'(d);
         repeat (7) @(negedge clk);
         rd(0, A_CLO, d); chk($sformatf("R2 psc%0d hold", p), 64'(d), k);
      end

      // R4/R6: compare distances across the 32-bit boundary, every core
      for (int c = 0; c < NCH; c++)
         for (int dd = 0; dd < 4; dd++) begin
            stop_clear(CIW'(c));
            wr(CIW'(c), A_CLO, 32'hFFFF_FFFE);
            wr(CIW'(c), A_CHI, 32'h0);
            k = 64'h0_FFFF_FFFE + 64'(dd);
            wr(CIW'(c), A_KLO, k[31:0]);
            wr(CIW'(c), A_KHI, k[63:32]);
            wr(CIW'(c), A_CTL, 32'h7);
            repeat (dd) @(negedge clk);
            rd(CIW'(c), A_STA, d);
            chk($sformatf("R4 core%0d d%0d early", c, dd), 64'(d), 64'd0);
            chk($sformatf("R6 core%0d d%0d irq low", c, dd), 64'(irq[c]), 64'd0);
            @(negedge clk);
            rd(CIW'(c), A_STA, d);
            chk($sformatf("R4 core%0d d%0d hit", c, dd), 64'(d), 64'd1);
            chk($sformatf("R6 core%0d d%0d irq", c, dd), 64'(irq), 64'(1 << c));
            if (dd == 3) begin
               rd(CIW'(c), A_CHI, d); chk("R3 carry hi", 64'(d), 64'd1);
               rd(CIW'(c), A_CLO, d); chk("R3 carry lo", 64'(d), 64'd2);
            end
            stop_clear(CIW'(c));
         end
      chk("R6 all irq low", 64'(irq), 64'd0);

      // R5: periodic reload by 4
      stop_clear(1);
      wr(1, A_CLO, 0); wr(1, A_CHI, 0);
      wr(1, A_KLO, 3); wr(1, A_KHI, 0);
      wr(1, A_STP, 4);
      wr(1, A_CTL, 32'hB);
      repeat (3) @(negedge clk);
      rd(1, A_KLO, d); chk("R5 cmp before", 64'(d), 64'd3);
      @(negedge clk);
      rd(1, A_KLO, d); chk("R5 cmp first", 64'(d), 64'd7);
      rd(1, A_STA, d); chk("R5 flag", 64'(d), 64'd1);
      chk("R6 irq masked", 64'(irq[1]), 64'd0);
      repeat (4) @(negedge clk);
      rd(1, A_KLO, d); chk("R5 cmp second", 64'(d), 64'd11);
      wr(1, A_CTL, 32'h0);
      wr(1, A_CTL, 32'h4);
      chk("R6 irq unmasked", 64'(irq[1]), 64'd1);
      stop_clear(1);

      // R5: at most one step per clock
      stop_clear(2);
      wr(2, A_CLO, 10); wr(2, A_CHI, 0);
      wr(2, A_KLO, 0); wr(2, A_KHI, 0);
      wr(2, A_STP, 1);
      wr(2, A_CTL, 32'hB);
      repeat (5) @(negedge clk);
      rd(2, A_KLO, d); chk("R5 one per clock", 64'(d), 64'd5);
      rd(2, A_CLO, d); chk("R2 count 15", 64'(d), 64'd15);
      stop_clear(2);

      // R5: zero step
      stop_clear(0);
      wr(0, A_CLO, 0); wr(0, A_CHI, 0);
      wr(0, A_KLO, 2); wr(0, A_KHI, 0);
      wr(0, A_STP, 0);
      wr(0, A_CTL, 32'hB);
      repeat (10) @(negedge clk);
      rd(0, A_KLO, d); chk("R5 zero step cmp", 64'(d), 64'd2);
      rd(0, A_STA, d); chk("R5 zero step flag", 64'(d), 64'd1);
      stop_clear(0);

      // R4: both enables required
      wr(0, A_CLO, 5); wr(0, A_KLO, 0);
      wr(0, A_CTL, 32'h1);
      repeat (6) @(negedge clk);
      rd(0, A_STA, d); chk("R4 no cmp_en", 64'(d), 64'd0);
      wr(0, A_CTL, 32'h2);
      repeat (6) @(negedge clk);
      rd(0, A_STA, d); chk("R4 no run", 64'(d), 64'd0);
      wr(0, A_CTL, 32'h3);
      @(negedge clk);
      rd(0, A_STA, d); chk("R4 both set", 64'(d), 64'd1);

      // R7: write-one-to-clear
      wr(0, A_CTL, 32'h4);
      wr(0, A_STA, 32'h0);
      rd(0, A_STA, d); chk("R7 write 0 keeps", 64'(d), 64'd1);
      wr(0, A_STA, 32'hFFFF_FFFE);
      rd(0, A_STA, d); chk("R7 other bits keep", 64'(d), 64'd1);
      wr(0, A_STA, 32'h1);
      rd(0, A_STA, d); chk("R7 cleared", 64'(d), 64'd0);
      chk("R7 irq low", 64'(irq[0]), 64'd0);

      // R8: split control
      wr(0, A_CTL, 32'h0000_0506);
      rd(1, A_CTL, d); chk("R8 core1 sees shared", 64'(d), 64'h500);
      rd(0, A_CTL, d); chk("R8 core0 own", 64'(d), 64'h506);
      wr(1, A_CTL, 32'h0000_0309);
      rd(0, A_CTL, d); chk("R8 core0 after core1", 64'(d), 64'h307);
      rd(1, A_CTL, d); chk("R8 core1 own", 64'(d), 64'h309);
      wr(2, A_CTL, 32'hFFFF_FFF0);
      rd(2, A_CTL, d); chk("R8 junk masked", 64'(d), 64'hFF00);
      rd(0, A_CTL, d); chk("R8 core0 banked kept", 64'(d), 64'hFF06);
      wr(0, A_CTL, 0); wr(1, A_CTL, 0);

      // R9: map and unmapped offset
      wr(1, A_STP, 32'hDEAD_BEEF);
      wr(1, A_KHI, 32'h1234_5678);
      wr(1, A_BAD, 32'hFFFF_FFFF);
      rd(1, A_BAD, d); chk("R9 unmapped read", 64'(d), 64'd0);
      rd(1, A_STP, d); chk("R9 step", 64'(d), 64'hDEAD_BEEF);
      rd(1, A_KHI, d); chk("R9 cmp hi", 64'(d), 64'h1234_5678);
      rd(0, A_STP, d); chk("R9 step banked", 64'(d), 64'd0);

      // R10: out-of-range core
      wr(0, A_CLO, 32'h77);
      rd(3, A_CLO, d); chk("R10 read cnt", 64'(d), 64'd0);
      rd(3, A_CTL, d); chk("R10 read ctl", 64'(d), 64'd0);
      wr(3, A_CLO, 32'h99);
      wr(3, A_CTL, 32'h1);
      repeat (3) @(negedge clk);
      rd(0, A_CLO, d); chk("R10 write cnt ignored", 64'(d), 64'h77);
      rd(0, A_CTL, d); chk("R10 write ctl ignored", 64'(d), 64'd0);

      done = 1'b1;
      finish_run();
   end
endmodule